// File: doc/BRIEF.md
# Inverse-Square-Root Incremental Scanner

The block takes an unsigned fractional sample Y, the reading of a sensor whose value equals 1/D², and recovers the integer D. It does not divide and it does not take a square root. Instead it tries D = 0, 1, 2, ... one candidate per clock and keeps the product Y·D² in a running accumulator. Each candidate costs two additions. The step from D to D+1 adds the increment 2YD + Y to the product, and the increment itself grows by 2Y. The search ends on the first candidate whose product reaches or passes fixed-point 1.0.

Y has `YW` bits, and all of them are fractional, so the value of Y is y/2^YW. The candidate D has `DW` bits. The accumulators are 2·DW+YW bits wide, so no sum can wrap before the compare. The parameter `ROUND_BELOW` chooses what is reported. With 0 the block reports the crossing D, the smallest D with Y·D² ≥ 1.0. With 1 it reports that D minus one, the largest D with Y·D² < 1.0.

A request on `start_i` is accepted only while the block is idle. `busy_o` is high while the search runs. When the search ends, `done_o` pulses for one cycle, and the result and the overflow flag are presented at the same time.

Top module: `invsqrt_scan`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `busy_o`, `done_o`, `d_o` and `ovf_o` are all 0.
- R2: A `start_i` seen at a clock edge while idle captures `y_i`, and from that edge `busy_o` is 1.
- R3: With `ROUND_BELOW`=0, `d_o` is the smallest D with y·D² ≥ 2^YW. With `ROUND_BELOW`=1, `d_o` is that D minus 1.
- R4: If the start is captured at edge E and the search ends on candidate Dc, then `done_o` rises after edge E+1+Dc. `busy_o` stays 1 until that same edge.
- R5: If no D up to 2^DW−1 reaches 1.0, which includes y = 0, then `ovf_o` is 1 and `d_o` is 2^DW−1 for either rounding choice. Otherwise `ovf_o` is 0.
- R6: `done_o` is high for exactly one cycle and is never high while `busy_o` is high.
- R7: A `start_i` while `busy_o` is 1 is ignored. The search in progress and its result are unchanged.
- R8: `d_o` and `ovf_o` change only on the cycle in which `done_o` is high, and they hold otherwise.
- R9: A product exactly equal to 1.0 counts as a crossing. For example, y = 2^(YW−2) gives D = 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a new search with `y_i` |
| y_i | input | YW | Sample, value y/2^YW |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle pulse at the end of a search |
| d_o | output | DW | Recovered D |
| ovf_o | output | 1 | No crossing within range |

## Verification
The bench goes after the exact-1.0 boundary. A strict compare there would report 3 instead of 2 for y = 2^(YW−2). It also drives y = 0 and y = 1, where a design that missed the range limit would hang or wrap instead of flagging overflow at the maximum D. A second start is fired during a search; a design that accepted it would restart and return the second sample's D. A reference that counts cycles exposes any off-by-one in latency or in the D−1 rounding instance, and samples taken long after done expose outputs that drift.

// File: rtl/invsqrt_pkg.sv
package invsqrt_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} scan_state_e;

  function automatic int acc_width(input int dw, input int yw);
    return 2 * dw + yw;
  endfunction
endpackage

// File: rtl/invsqrt_acc.sv
// Second-difference accumulator pair: product Y*D^2 and its increment 2YD+Y.
module invsqrt_acc #(
  parameter int YW = 16,
  parameter int DW = 8,
  localparam int AW = invsqrt_pkg::acc_width(DW, YW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [YW-1:0] y_i,
  output logic          crossed_o
);
  localparam logic [AW-1:0] ONE = AW'(1) << YW;

  logic [AW-1:0] prod_q;   // Y*D^2
  logic [AW-1:0] incr_q;   // 2YD + Y
  logic [AW-1:0] twoy_q;   // 2Y

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      incr_q <= '0;
      twoy_q <= '0;
    end else if (load_i) begin
      prod_q <= '0;
      incr_q <= AW'(y_i);
      twoy_q <= AW'(y_i) << 1;
    end else if (step_i) begin
      prod_q <= prod_q + incr_q;
      incr_q <= incr_q + twoy_q;
    end
  end

  assign crossed_o = (prod_q >= ONE);

  // R3: the product never shrinks while scanning (no wrap)
  p_prod_grows_r3: assert property (@(posedge clk) disable iff (rst)
    step_i |=> prod_q >= $past(prod_q));
endmodule

// File: rtl/invsqrt_ctrl.sv
// Sequencer: candidate counter, termination and start acceptance.
module invsqrt_ctrl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          crossed_i,
  output logic          load_o,
  output logic          step_o,
  output logic          finish_o,
  output logic          hit_o,
  output logic          busy_o,
  output logic [DW-1:0] cand_o
);
  import invsqrt_pkg::*;
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  scan_state_e   state_q;
  logic [DW-1:0] cand_q;

  always_comb begin
    load_o   = (state_q == ST_IDLE) && start_i;
    hit_o    = (state_q == ST_RUN) && crossed_i;
    finish_o = (state_q == ST_RUN) && (crossed_i || cand_q == DMAX);
    step_o   = (state_q == ST_RUN) && !finish_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cand_q  <= '0;
    end else if (load_o) begin
      state_q <= ST_RUN;
      cand_q  <= '0;
    end else if (finish_o) begin
      state_q <= ST_IDLE;
    end else if (step_o) begin
      cand_q <= cand_q + DW'(1);
    end
  end

  assign busy_o = (state_q == ST_RUN);
  assign cand_o = cand_q;

  // R2: idle start begins a search at candidate 0
  p_start_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (busy_o && cand_q == '0));
  // R7: while running, a start has no effect: candidate keeps counting
  p_start_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !finish_o) |=> (busy_o && cand_q == $past(cand_q) + DW'(1)));
endmodule

// File: rtl/invsqrt_out.sv
// Result register with rounding variant chosen at elaboration.
module invsqrt_out #(
  parameter int DW          = 8,
  parameter bit ROUND_BELOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          finish_i,
  input  logic          hit_i,
  input  logic [DW-1:0] cand_i,
  output logic          done_o,
  output logic [DW-1:0] d_o,
  output logic          ovf_o
);
  localparam logic [DW-1:0] DMAX = {DW{1'b1}};

  logic [DW-1:0] rounded;

  generate
    if (ROUND_BELOW) begin : g_below
      assign rounded = cand_i - DW'(1);
    end else begin : g_at
      assign rounded = cand_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o <= 1'b0;
      d_o    <= '0;
      ovf_o  <= 1'b0;
    end else begin
      done_o <= finish_i;
      if (finish_i) begin
        d_o   <= hit_i ? rounded : DMAX;
        ovf_o <= !hit_i;
      end
    end
  end

  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R8: results hold outside the done cycle
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(d_o) && $stable(ovf_o)));
  // R5: overflow always reports the maximum D
  p_ovf_max_r5: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> d_o == DMAX);
endmodule

// File: rtl/invsqrt_scan.sv
module invsqrt_scan #(
  parameter int YW          = 16,
  parameter int DW          = 8,
  parameter bit ROUND_BELOW = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [YW-1:0] y_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] d_o,
  output logic          ovf_o
);
  logic          load, step, finish, hit, crossed;
  logic [DW-1:0] cand;

  invsqrt_ctrl #(.DW(DW)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .crossed_i(crossed),
    .load_o(load), .step_o(step), .finish_o(finish), .hit_o(hit),
    .busy_o(busy_o), .cand_o(cand)
  );

  invsqrt_acc #(.YW(YW), .DW(DW)) acc_i (
    .clk(clk), .rst(rst), .load_i(load), .step_i(step), .y_i(y_i),
    .crossed_o(crossed)
  );

  invsqrt_out #(.DW(DW), .ROUND_BELOW(ROUND_BELOW)) out_i (
    .clk(clk), .rst(rst), .finish_i(finish), .hit_i(hit), .cand_i(cand),
    .done_o(done_o), .d_o(d_o), .ovf_o(ovf_o)
  );

  // R6: done never coincides with an active search
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
endmodule

// File: tb/invsqrt_scan_tb.sv
`timescale 1ns/1ps
module invsqrt_scan_tb_top;
  localparam int YW = 16;
  localparam int DW = 8;
  localparam int DMAX = (1 << DW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [YW-1:0] y = '0;
  logic busy_a, done_a, ovf_a, busy_b, done_b, ovf_b;
  logic [DW-1:0] d_a, d_b;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  invsqrt_scan #(.YW(YW), .DW(DW), .ROUND_BELOW(1'b0)) dut_i (
    .clk(clk), .rst(rst), .start_i(start), .y_i(y),
    .busy_o(busy_a), .done_o(done_a), .d_o(d_a), .ovf_o(ovf_a));
  invsqrt_scan #(.YW(YW), .DW(DW), .ROUND_BELOW(1'b1)) dut_b (
    .clk(clk), .rst(rst), .start_i(start), .y_i(y),
    .busy_o(busy_b), .done_o(done_b), .d_o(d_b), .ovf_o(ovf_b));

  // Behavioural reference: target found by direct search with integers
  bit m_busy, m_done, m_ovf, t_ovf;
  int m_cnt, m_lat, m_da, m_db, t_d;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_done = 0; m_ovf = 0; m_da = 0; m_db = 0; m_cnt = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        if (m_cnt == m_lat) begin
          m_busy = 0; m_done = 1; m_ovf = t_ovf;
          m_da = t_ovf ? DMAX : t_d;
          m_db = t_ovf ? DMAX : t_d - 1;
        end else m_cnt++;
      end else if (start) begin
        m_busy = 1; m_cnt = 0; t_ovf = 1; t_d = DMAX;
        for (int k = 0; k <= DMAX; k++) begin
          if (t_ovf && longint'(y) * k * k >= (longint'(1) << YW)) begin
            t_ovf = 0; t_d = k;
          end
        end
        m_lat = t_d;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk("R4 busy", busy_a, m_busy);
      chk("R4 busy rb", busy_b, m_busy);
      chk("R6 done", done_a, m_done);
      chk("R6 done rb", done_b, m_done);
      chk("R3 d", d_a, m_da);
      chk("R3 d rb", d_b, m_db);
      chk("R5 ovf", ovf_a, m_ovf);
      chk("R5 ovf rb", ovf_b, m_ovf);
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic launch(input logic [YW-1:0] val);
    @(negedge clk); start = 1'b1; y = val;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_a) @(negedge clk);
  endtask

  task automatic run(input logic [YW-1:0] val, input int ea, input int eb,
                     input int eo, input string req);
    launch(val);
    chk({req, " busy after start"}, busy_a, 1);
    wait_done();
    chk({req, " d"}, d_a, ea);
    chk({req, " d rb"}, d_b, eb);
    chk({req, " ovf"}, ovf_a, eo);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy_a, 0);
    chk("R1 done in reset", done_a, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 d", d_a, 0);
    chk("R1 ovf", ovf_a, 0);
    run(16'd16384, 2, 1, 0, "R9");
    run(16'd16383, 3, 2, 0, "R3");
    run(16'hFFFF, 2, 1, 0, "R3");
    run(16'd1000, 9, 8, 0, "R3");
    run(16'd2, 182, 181, 0, "R4");
    run(16'd1, DMAX, DMAX, 1, "R5");
    run(16'd0, DMAX, DMAX, 1, "R5");
    // R7: second start mid-search must be ignored
    launch(16'd1000);
    chk("R2 busy", busy_a, 1);
    @(negedge clk); start = 1'b1; y = 16'hFFFF;
    @(negedge clk); start = 1'b0; y = '0;
    wait_done();
    chk("R7 d", d_a, 9);
    chk("R7 d rb", d_b, 8);
    // R8: results hold long after done
    repeat (20) @(negedge clk);
    chk("R8 d hold", d_a, 9);
    chk("R8 ovf hold", ovf_a, 0);
    chk("R6 done low", done_a, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule